// File: doc/BRIEF.md
# Line-Oriented DMA Instruction Sequencer

This engine walks a program of 32-bit instruction dwords held in bus memory. It uses the program to move captured scan-line data out of an on-chip FIFO to bus addresses. A line may be spread over several address chunks. Each chunk is a separate write request. The write request carries start-of-line and end-of-line markers, so the receiving side can rebuild line boundaries.

The same instruction stream carries the control events:
- line-count interrupts;
- event-counter updates;
- waits for the start of a field;
- a closing jump, which normally returns to the first instruction.

Software places a program in memory, sets the initial address and raises the enable. Dropping the enable returns the engine to idle.

Top module: `line_dma_seq`

## Requirements
- R1: While reset is asserted, or in the cycle after `en` is sampled low, the engine is idle. In that state `fetch_req`, `wr_req`, `irq1`, `irq2` and `evt_cnt` are all zero. `err_sticky` is cleared only by reset.
- R2: When enabled from idle, the first dword fetched is at `start_addr`.
- R3: The opcode is bits 31:28 of the first dword. The following opcodes are defined:
  - 0x1 (write) and 0x7 (jump) use 2 dwords.
  - 0xB and 0xC use 3 dwords, and 0xD uses 4 dwords. These three are skipped without fetching their extra dwords.
  - 0x2 (no-op skip) and 0x8 (sync) use 1 dword.
- R4: A write takes its address from its second dword and its byte count from bits 11:0. Bit 27 drives `wr_sol` and bit 26 drives `wr_eol`. The request stays asserted with a stable address and count until `wr_ack`.
- R5: A write with a non-zero count stalls without a request until `fifo_level` is at least the count. A write with count zero completes with no request.
- R6: A jump loads the program counter from its second dword.
- R7: A sync with bit 15 set stalls until `cur_line` equals its low `LINE_W` bits. A sync with bit 15 clear continues at once.
- R8: Bit 24 and bit 25 of an accepted opcode dword each give a one-cycle pulse on `irq1` and `irq2` respectively, in the cycle after acceptance.
- R9: In the same cycle as R8, bit 16 increments `evt_cnt` and bit 17 clears it. When both are set, the result is 1.
- R10: Any other opcode halts the engine, sets `err_sticky` and pulses `err_irq` for one cycle.
- R11: `fetch_req` and `wr_req` are never high together. A pending fetch holds its address until `fetch_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low returns to idle |
| start_addr | input | AW | Initial program address |
| fetch_req | output | 1 | Instruction dword fetch request |
| fetch_addr | output | AW | Byte address of requested dword |
| fetch_data | input | 32 | Returned dword |
| fetch_valid | input | 1 | Fetch data valid, completes the fetch |
| wr_req | output | 1 | Write burst request |
| wr_addr | output | 32 | Write burst bus address |
| wr_bytes | output | CNT_W | Write burst byte count |
| wr_sol | output | 1 | Burst begins a line |
| wr_eol | output | 1 | Burst ends a line |
| wr_ack | input | 1 | Write burst accepted |
| fifo_level | input | LVL_W | Bytes available in the capture FIFO |
| cur_line | input | LINE_W | Current line number of the capture side |
| irq1 | output | 1 | Interrupt 1 pulse |
| irq2 | output | 1 | Interrupt 2 pulse |
| err_irq | output | 1 | Illegal-opcode interrupt pulse |
| err_sticky | output | 1 | Illegal opcode seen since reset |
| evt_cnt | output | EVT_W | Event counter |

## Verification
The assertions check the following on every cycle:
- fetch and write requests never overlap;
- a pending fetch and a pending write hold their address and count;
- no request is made for a zero count;
- the engine is quiet after disable and after an illegal opcode;
- the event counter clears when it is told to.

Only the bench scenarios can show program-level behaviour: the sequence of fetch addresses through skipped masked variants and jumps, the split-line write chain with its markers, interrupt pulses paired with counter values, and stalls on a field line or a FIFO one byte short.

// File: rtl/lds_pkg.sv
package lds_pkg;
  localparam logic [3:0] OP_WRITE = 4'h1;
  localparam logic [3:0] OP_SKIP  = 4'h2;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_SYNC  = 4'h8;
  localparam logic [3:0] OP_MWR3A = 4'hB;
  localparam logic [3:0] OP_MWR3B = 4'hC;
  localparam logic [3:0] OP_MWR4  = 4'hD;

  localparam int B_SOL    = 27;
  localparam int B_EOL    = 26;
  localparam int B_IRQ2   = 25;
  localparam int B_IRQ1   = 24;
  localparam int B_CLR    = 17;
  localparam int B_INC    = 16;
  localparam int B_RESYNC = 15;

  typedef enum logic [2:0] {K_WRITE, K_JUMP, K_SYNC, K_NOP, K_MASKED, K_BAD} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ARG, S_DATA, S_BUS, S_SYNC, S_HALT} state_e;
endpackage

// File: rtl/lds_decode.sv
module lds_decode
  import lds_pkg::*;
(
  input  logic [3:0] op,
  output kind_e      kind,
  output logic [2:0] ndw
);
  always_comb begin
    kind = K_BAD;
    ndw  = 3'd1;
    case (op)
      OP_WRITE: begin kind = K_WRITE;  ndw = 3'd2; end
      OP_JUMP:  begin kind = K_JUMP;   ndw = 3'd2; end
      OP_SYNC:  begin kind = K_SYNC;   ndw = 3'd1; end
      OP_SKIP:  begin kind = K_NOP;    ndw = 3'd1; end
      OP_MWR3A: begin kind = K_MASKED; ndw = 3'd3; end
      OP_MWR3B: begin kind = K_MASKED; ndw = 3'd3; end
      OP_MWR4:  begin kind = K_MASKED; ndw = 3'd4; end
      default:  begin kind = K_BAD;    ndw = 3'd1; end
    endcase
  end
endmodule

// File: rtl/lds_events.sv
module lds_events #(
  parameter int EVT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fire,
  input  logic             f_irq1,
  input  logic             f_irq2,
  input  logic             f_inc,
  input  logic             f_clr,
  output logic             irq1,
  output logic             irq2,
  output logic [EVT_W-1:0] evt_cnt
);
  logic [EVT_W-1:0] cnt_d;
  logic             irq1_d, irq2_d;

  always_comb begin
    cnt_d  = evt_cnt;
    irq1_d = 1'b0;
    irq2_d = 1'b0;
    if (!en) begin
      cnt_d = '0;
    end else if (fire) begin
      irq1_d = f_irq1;
      irq2_d = f_irq2;
      if (f_clr)      cnt_d = f_inc ? EVT_W'(1) : '0;
      else if (f_inc) cnt_d = evt_cnt + EVT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_cnt <= '0;
      irq1    <= 1'b0;
      irq2    <= 1'b0;
    end else begin
      evt_cnt <= cnt_d;
      irq1    <= irq1_d;
      irq2    <= irq2_d;
    end
  end

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fire && f_clr && !f_inc) |=> (evt_cnt == '0));
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fire && f_irq1) |=> irq1);
endmodule

// File: rtl/line_dma_seq.sv
module line_dma_seq
  import lds_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CNT_W  = 12,
  parameter int LVL_W  = 13,
  parameter int LINE_W = 10,
  parameter int EVT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [AW-1:0]     start_addr,
  output logic              fetch_req,
  output logic [AW-1:0]     fetch_addr,
  input  logic [31:0]       fetch_data,
  input  logic              fetch_valid,
  output logic              wr_req,
  output logic [31:0]       wr_addr,
  output logic [CNT_W-1:0]  wr_bytes,
  output logic              wr_sol,
  output logic              wr_eol,
  input  logic              wr_ack,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [LINE_W-1:0] cur_line,
  output logic              irq1,
  output logic              irq2,
  output logic              err_irq,
  output logic              err_sticky,
  output logic [EVT_W-1:0]  evt_cnt
);
  localparam logic [AW-1:0] DW_BYTES = AW'(4);

  state_e            state_q, state_d;
  logic [AW-1:0]     pc_q, pc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [31:0]       waddr_q, waddr_d;
  logic              sol_q, sol_d, eol_q, eol_d, jmp_q, jmp_d;
  logic              err_q, err_d, eirq_d;
  logic              fire, bad;
  kind_e             kind;
  logic [2:0]        ndw;

  lds_decode u_dec (
    .op   (fetch_data[31:28]),
    .kind (kind),
    .ndw  (ndw)
  );

  lds_events #(.EVT_W(EVT_W)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .fire    (fire),
    .f_irq1  (fetch_data[B_IRQ1]),
    .f_irq2  (fetch_data[B_IRQ2]),
    .f_inc   (fetch_data[B_INC]),
    .f_clr   (fetch_data[B_CLR]),
    .irq1    (irq1),
    .irq2    (irq2),
    .evt_cnt (evt_cnt)
  );

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    cnt_d   = cnt_q;
    line_d  = line_q;
    waddr_d = waddr_q;
    sol_d   = sol_q;
    eol_d   = eol_q;
    jmp_d   = jmp_q;
    fire    = 1'b0;
    bad     = 1'b0;
    case (state_q)
      S_IDLE: begin
        state_d = S_FETCH;
        pc_d    = start_addr;
      end
      S_FETCH: begin
        if (fetch_valid) begin
          fire   = 1'b1;
          cnt_d  = fetch_data[CNT_W-1:0];
          line_d = fetch_data[LINE_W-1:0];
          sol_d  = fetch_data[B_SOL];
          eol_d  = fetch_data[B_EOL];
          case (kind)
            K_WRITE: begin jmp_d = 1'b0; pc_d = pc_q + DW_BYTES; state_d = S_ARG; end
            K_JUMP:  begin jmp_d = 1'b1; pc_d = pc_q + DW_BYTES; state_d = S_ARG; end
            K_SYNC: begin
              pc_d    = pc_q + DW_BYTES;
              state_d = fetch_data[B_RESYNC] ? S_SYNC : S_FETCH;
            end
            K_BAD: begin bad = 1'b1; state_d = S_HALT; end
            default: pc_d = pc_q + AW'({ndw, 2'b00});
          endcase
        end
      end
      S_ARG: begin
        if (fetch_valid) begin
          if (jmp_q) begin
            pc_d    = fetch_data[AW-1:0];
            state_d = S_FETCH;
          end else begin
            waddr_d = fetch_data;
            pc_d    = pc_q + DW_BYTES;
            state_d = (cnt_q == '0) ? S_FETCH : S_DATA;
          end
        end
      end
      S_DATA: if (fifo_level >= LVL_W'(cnt_q)) state_d = S_BUS;
      S_BUS:  if (wr_ack) state_d = S_FETCH;
      S_SYNC: if (cur_line == line_q) state_d = S_FETCH;
      default: state_d = S_HALT;
    endcase
    if (!en) begin
      state_d = S_IDLE;
      bad     = 1'b0;
    end
    err_d  = err_q | bad;
    eirq_d = bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      cnt_q   <= '0;
      line_q  <= '0;
      waddr_q <= '0;
      sol_q   <= 1'b0;
      eol_q   <= 1'b0;
      jmp_q   <= 1'b0;
      err_q   <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      cnt_q   <= cnt_d;
      line_q  <= line_d;
      waddr_q <= waddr_d;
      sol_q   <= sol_d;
      eol_q   <= eol_d;
      jmp_q   <= jmp_d;
      err_q   <= err_d;
      err_irq <= eirq_d;
    end
  end

  assign fetch_req  = (state_q == S_FETCH) || (state_q == S_ARG);
  assign fetch_addr = pc_q;
  assign wr_req     = (state_q == S_BUS);
  assign wr_addr    = waddr_q;
  assign wr_bytes   = cnt_q;
  assign wr_sol     = sol_q;
  assign wr_eol     = eol_q;
  assign err_sticky = err_q;

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req && wr_req));
  assert_fetch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (fetch_req && !fetch_valid) |=> (fetch_req && $stable(fetch_addr)));
  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_bytes)));
  assert_no_zero_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_bytes != '0));
  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (!fetch_req && !wr_req && err_sticky));
  assert_disable_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!fetch_req && !wr_req));
endmodule

// File: tb/line_dma_seq_bench.sv
module line_dma_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n, en;
  logic [31:0] start_addr, fetch_addr, fetch_data, wr_addr;
  logic        fetch_req, fetch_valid, wr_req, wr_sol, wr_eol, wr_ack;
  logic [11:0] wr_bytes;
  logic [12:0] fifo_level;
  logic [9:0]  cur_line;
  logic        irq1, irq2, err_irq, err_sticky;
  logic [15:0] evt_cnt;
  logic [31:0] mem [0:63];
  int          cyc, ackcnt, checks, errors, eirq_seen;
  logic [63:0] obs_f[$], obs_w[$], obs_i[$], exp_f[$], exp_w[$], exp_i[$];

  always #10 clk = ~clk;

  line_dma_seq u_line_dma_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .start_addr(start_addr),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
    .fetch_valid(fetch_valid), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_bytes(wr_bytes), .wr_sol(wr_sol), .wr_eol(wr_eol), .wr_ack(wr_ack),
    .fifo_level(fifo_level), .cur_line(cur_line), .irq1(irq1), .irq2(irq2),
    .err_irq(err_irq), .err_sticky(err_sticky), .evt_cnt(evt_cnt)
  );

  assign fetch_data  = mem[fetch_addr[7:2]];
  assign fetch_valid = fetch_req && (cyc % 3 != 1);
  assign wr_ack      = wr_req && (ackcnt == 2);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    ackcnt <= (wr_req && !wr_ack) ? ackcnt + 1 : 0;
  end

  function automatic logic [63:0] pack_w(logic [31:0] a, logic [11:0] c, logic s, logic e);
    return {a, 4'd0, c, 14'd0, s, e};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (fetch_req && fetch_valid) obs_f.push_back(64'(fetch_addr));
      if (wr_req && wr_ack) obs_w.push_back(pack_w(wr_addr, wr_bytes, wr_sol, wr_eol));
      if (irq1 || irq2) obs_i.push_back({46'd0, irq1, irq2, evt_cnt});
      if (err_irq) eirq_seen++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_q();
    obs_f.delete(); obs_w.delete(); obs_i.delete();
    exp_f.delete(); exp_w.delete(); exp_i.delete();
  endtask

  // behavioural reference: walks the program, lists expected events
  task automatic model_run(input int start, input int n);
    int pc = start;
    int ev = 0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] w = mem[(pc >> 2) & 63];
      exp_f.push_back(64'(pc));
      if (w[17]) ev = w[16] ? 1 : 0;
      else if (w[16]) ev = ev + 1;
      if (w[24] || w[25]) exp_i.push_back({46'd0, w[24], w[25], 16'(ev)});
      case (w[31:28])
        4'h1: begin
          exp_f.push_back(64'(pc + 4));
          if (w[11:0] != 0) exp_w.push_back(pack_w(mem[((pc + 4) >> 2) & 63], w[11:0], w[27], w[26]));
          pc += 8;
        end
        4'h7: begin exp_f.push_back(64'(pc + 4)); pc = int'(mem[((pc + 4) >> 2) & 63]); end
        4'h2, 4'h8: pc += 4;
        4'hB, 4'hC: pc += 12;
        4'hD: pc += 16;
        default: break;
      endcase
    end
  endtask

  task automatic compare(input string tag, ref logic [63:0] o[$], ref logic [63:0] e[$]);
    check(o.size() >= e.size(), {tag, " count"}, 64'(o.size()), 64'(e.size()));
    for (int i = 0; i < e.size() && i < o.size(); i++)
      check(o[i] === e[i], tag, o[i], e[i]);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit hit;
    checks = 0; errors = 0; eirq_seen = 0; cyc = 0; ackcnt = 0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    // program A at 0x00: split line, masked skip, zero write, sync, loop
    mem[0]  = 32'h2101_0000; mem[1]  = 32'h1800_0064; mem[2]  = 32'h0000_1000;
    mem[3]  = 32'h1000_00C8; mem[4]  = 32'h0000_2000; mem[5]  = 32'h1400_0032;
    mem[6]  = 32'h0000_3000; mem[7]  = 32'h1D01_0040; mem[8]  = 32'h0000_4000;
    mem[9]  = 32'hC000_0000; mem[10] = 32'hFFFF_FFFF; mem[11] = 32'h0000_0000;
    mem[12] = 32'h1C00_0000; mem[13] = 32'h0000_5000; mem[14] = 32'h8000_0000;
    mem[15] = 32'h2202_0000; mem[16] = 32'h7000_0000; mem[17] = 32'h0000_0000;
    // program B at 0x80: resync to second field, one whole line, loop
    mem[32] = 32'h8000_8200; mem[33] = 32'h1C00_0010; mem[34] = 32'h0000_6000;
    mem[35] = 32'h7000_0000; mem[36] = 32'h0000_0080;
    // program C at 0xA0: undefined opcode
    mem[40] = 32'h3000_0000;

    rst_n = 1'b0; en = 1'b0; start_addr = 32'h0; fifo_level = 13'd4095; cur_line = 10'd0;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    check(!fetch_req && !wr_req, "R1 reset idle", {fetch_req, wr_req}, 0);
    check(evt_cnt == 0 && !err_sticky && !irq1, "R1 reset state", {err_sticky, evt_cnt}, 0);

    // program A
    en = 1'b1;
    cycles(400);
    en = 1'b0;
    model_run(0, 14);
    check(obs_f.size() > 0 && obs_f[0] == 0, "R2 first fetch", obs_f[0], 0);
    compare("R3 R6 fetch order", obs_f, exp_f);
    compare("R4 write chain", obs_w, exp_w);
    compare("R8 R9 irq and counter", obs_i, exp_i);
    hit = 0;
    foreach (obs_w[i]) if (obs_w[i][63:32] == 32'h5000) hit = 1;
    check(!hit, "R5 zero count no request", 64'(hit), 0);
    cycles(2);
    check(!fetch_req && !wr_req && evt_cnt == 0, "R1 disable idle", {fetch_req, wr_req, evt_cnt}, 0);

    // program B
    clear_q();
    start_addr = 32'h80; fifo_level = 13'd15; cur_line = 10'd3; en = 1'b1;
    cycles(30);
    check(!fetch_req && !wr_req && obs_f.size() == 1, "R7 resync wait", 64'(obs_f.size()), 1);
    cur_line = 10'h200;
    cycles(30);
    check(!wr_req && !fetch_req && obs_w.size() == 0, "R5 fifo one short", 64'(obs_w.size()), 0);
    fifo_level = 13'd16; cur_line = 10'd3;
    cycles(20);
    check(obs_w.size() == 1, "R5 write after fifo ready", 64'(obs_w.size()), 1);
    if (obs_w.size() > 0)
      check(obs_w[0] == pack_w(32'h6000, 12'd16, 1'b1, 1'b1), "R4 whole line", obs_w[0],
            pack_w(32'h6000, 12'd16, 1'b1, 1'b1));
    check(obs_f.size() > 0 && obs_f[obs_f.size()-1] == 64'h80 && !fetch_req,
          "R6 R7 loop back and wait", obs_f[obs_f.size()-1], 64'h80);
    en = 1'b0;
    cycles(3);

    // program C
    clear_q();
    start_addr = 32'hA0; en = 1'b1;
    cycles(10);
    check(err_sticky && eirq_seen == 1, "R10 error flag", {err_sticky, 32'(eirq_seen)}, {1'b1, 32'd1});
    check(!fetch_req && !wr_req && obs_f.size() == 1, "R10 halted", 64'(obs_f.size()), 1);
    en = 1'b0;
    cycles(3);
    check(err_sticky, "R10 sticky after disable", 64'(err_sticky), 1);
    rst_n = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(1);
    check(!err_sticky, "R1 reset clears error", 64'(err_sticky), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule